// File: doc/BRIEF.md
# Eight-Channel Output Fault Qualifier and Protection Gate

This block sits between the command register of a serial-controlled octal power switch and its gate drivers. It keeps the on/off request and the load-detection-current enable of every channel, and it turns them into the gate-drive enables that actually reach the output transistors. A channel's own thermal alarm removes its enable. Supply overvoltage or undervoltage, or the enable pin going low, remove every enable at once.

Alongside the gating it builds the per-channel fault flags that the serial interface shifts out as status. Comparator and thermal reports are ignored for a programmable settling window after each command update. The way a comparator trip is read depends on the channel's commanded state. A qualified fault stays latched until the interface takes its status snapshot. Undervoltage and sleep clear all of the block's state. Overvoltage keeps that state, so the outputs come back unchanged when the supply recovers.

Top module: `outdrv_fault_guard`

## Requirements
- R1: While reset is asserted, and after it is released with no further stimulus, every status flag is 0 and every gate-drive enable is 0.
- R2: When `cmd_latch_i` is high in a cycle, the command register takes `cmd_word_i` at that clock edge. Bits [NCH-1:0] are the per-channel on-requests (1 = on). Bits [2*NCH-1:NCH] are the per-channel detection-current enables (1 = enabled). The gate enables follow the new on-requests from the next cycle on.
- R3: Comparator and thermal reports create no new flag in the cycle that carries `cmd_latch_i` or in the BLANK_CYC cycles that follow it. A latch that arrives during a window restarts the window.
- R4: For a channel commanded off, a comparator trip is flagged only when that channel's detection-current enable is 1. Otherwise the flag stays 0.
- R5: For a channel commanded on, a comparator trip or a thermal alarm is flagged whatever the value of the detection-current enable.
- R6: A flag stays at 1 after its condition clears and holds until a cycle with `snap_i` high. In that cycle the flag takes the value of the current qualified condition, so it stays at 1 if the fault is still present and qualified.
- R7: A thermal alarm on a channel drops only that channel's gate enable. When the alarm clears, the enable returns to the commanded state without any new command.
- R8: While `ov_i` is high, all gate enables are 0. When `ov_i` falls, each enable returns to its commanded state without any new command.
- R9: While `uv_i` is high, all gate enables are 0 and the command register and the flags are cleared. After recovery the outputs stay off until a new command is latched.
- R10: While `en_i` is low, the block acts as it does under undervoltage: all gate enables are 0 and all state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Device enable; low selects sleep |
| cmd_latch_i | input | 1 | One-cycle strobe marking an accepted command word |
| cmd_word_i | input | 2*NCH | Command word: on-requests in the low half, detection-current enables in the high half |
| cmp_trip_i | input | NCH | Per-channel drain-source comparator trip |
| therm_i | input | NCH | Per-channel overtemperature alarm |
| ov_i | input | 1 | Supply overvoltage |
| uv_i | input | 1 | Undervoltage on either supply |
| snap_i | input | 1 | Status snapshot strobe from the serial interface |
| flags_o | output | NCH | Latched per-channel fault flags |
| gate_en_o | output | NCH | Per-channel gate-drive enables |

## Verification
Two functions can act in the same cycle: the snapshot clear and the qualification of a fault that is still present. The bench provokes this by holding a comparator trip or a thermal alarm high across a `snap_i` pulse once the blanking window has run out. It also does this with a command latch and a snapshot arriving together, so that the window and the clear meet in one cycle. A behavioural model in the bench predicts the flags and enables cycle by cycle. A surviving flag must read 1 after the snapshot, while flags whose condition has gone must read 0.

// File: rtl/ofg_pkg.sv
package ofg_pkg;

   // Decide whether one channel's raw reports make a fault worth flagging.
   function automatic logic ofg_judge(input logic on_req,
                                      input logic det_en,
                                      input logic trip,
                                      input logic hot);
      logic res;
      if (on_req) res = trip | hot;
      else        res = trip & det_en;
      return res;
   endfunction

endpackage

// File: rtl/ofg_blank_timer.sv
module ofg_blank_timer #(
   parameter int BLANK_CYC = 5000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic start_i,
   output logic blank_o
);
   localparam int CW = $clog2(BLANK_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (clr_i)        cnt_q <= '0;
      else if (start_i)      cnt_q <= LOAD;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign blank_o = start_i | (cnt_q != '0);

   // The window must be open in the cycle after a restart.
   assert_window_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !clr_i) |=> blank_o);

endmodule

// File: rtl/ofg_flag_bank.sv
module ofg_flag_bank
   import ofg_pkg::*;
#(
   parameter int NCH = 8
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           clr_i,
   input  logic           blank_i,
   input  logic           snap_i,
   input  logic [NCH-1:0] on_i,
   input  logic [NCH-1:0] det_i,
   input  logic [NCH-1:0] trip_i,
   input  logic [NCH-1:0] hot_i,
   output logic [NCH-1:0] flags_o
);
   logic [NCH-1:0] flag_q;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit;
      assign hit = !blank_i && ofg_judge(on_i[c], det_i[c], trip_i[c], hot_i[c]);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      flag_q[c] <= 1'b0;
         else if (clr_i)   flag_q[c] <= 1'b0;
         else if (snap_i)  flag_q[c] <= hit;
         else              flag_q[c] <= flag_q[c] | hit;
      end

      assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (flag_q[c] && !snap_i && !clr_i) |=> flag_q[c]);

      assert_off_masked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!clr_i && !blank_i && !on_i[c] && !det_i[c] && (snap_i || !flag_q[c]))
         |=> !flag_q[c]);

      assert_on_hot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!clr_i && !blank_i && on_i[c] && hot_i[c]) |=> flag_q[c]);
   end

   assign flags_o = flag_q;

endmodule

// File: rtl/ofg_gate_ctrl.sv
module ofg_gate_ctrl #(
   parameter int NCH      = 8,
   parameter bit GATE_REG = 1'b0
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [NCH-1:0] on_i,
   input  logic [NCH-1:0] hot_i,
   input  logic           ov_i,
   input  logic           uv_i,
   input  logic           en_i,
   output logic [NCH-1:0] gate_o
);
   logic           rail_ok;
   logic [NCH-1:0] want;

   assign rail_ok = en_i & ~ov_i & ~uv_i;
   assign want    = on_i & ~hot_i & {NCH{rail_ok}};

   if (GATE_REG) begin : g_reg
      logic [NCH-1:0] gate_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) gate_q <= '0;
         else         gate_q <= want;
      end
      assign gate_o = gate_q;

      assert_rail_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (ov_i || uv_i || !en_i) |=> (gate_o == '0));
   end else begin : g_comb
      assign gate_o = want;

      assert_rail_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (ov_i || uv_i || !en_i) |-> (gate_o == '0));

      for (genvar c = 0; c < NCH; c++) begin : g_hot
         assert_hot_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            hot_i[c] |-> !gate_o[c]);
      end
   end

endmodule

// File: rtl/outdrv_fault_guard.sv
module outdrv_fault_guard #(
   parameter int NCH       = 8,
   parameter int BLANK_CYC = 5000,
   parameter bit GATE_REG  = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             cmd_latch_i,
   input  logic [2*NCH-1:0] cmd_word_i,
   input  logic [NCH-1:0]   cmp_trip_i,
   input  logic [NCH-1:0]   therm_i,
   input  logic             ov_i,
   input  logic             uv_i,
   input  logic             snap_i,
   output logic [NCH-1:0]   flags_o,
   output logic [NCH-1:0]   gate_en_o
);
   if (NCH < 1 || NCH > 32) begin : g_bad_nch
      $error("outdrv_fault_guard: NCH must lie in 1..32");
   end
   if (BLANK_CYC < 1) begin : g_bad_blank
      $error("outdrv_fault_guard: BLANK_CYC must be at least 1");
   end

   logic           wipe;
   logic           blank;
   logic [NCH-1:0] on_q;
   logic [NCH-1:0] det_q;

   assign wipe = uv_i | ~en_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         on_q  <= '0;
         det_q <= '0;
      end else if (wipe) begin
         on_q  <= '0;
         det_q <= '0;
      end else if (cmd_latch_i) begin
         on_q  <= cmd_word_i[NCH-1:0];
         det_q <= cmd_word_i[2*NCH-1:NCH];
      end
   end

   ofg_blank_timer #(.BLANK_CYC(BLANK_CYC)) i_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (wipe),
      .start_i (cmd_latch_i),
      .blank_o (blank)
   );

   ofg_flag_bank #(.NCH(NCH)) i_flags (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (wipe),
      .blank_i (blank),
      .snap_i  (snap_i),
      .on_i    (on_q),
      .det_i   (det_q),
      .trip_i  (cmp_trip_i),
      .hot_i   (therm_i),
      .flags_o (flags_o)
   );

   ofg_gate_ctrl #(.NCH(NCH), .GATE_REG(GATE_REG)) i_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .on_i   (on_q),
      .hot_i  (therm_i),
      .ov_i   (ov_i),
      .uv_i   (uv_i),
      .en_i   (en_i),
      .gate_o (gate_en_o)
   );

   // Blanked cycles must not alter the flags unless a snapshot or wipe intervenes.
   assert_blank_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blank && !snap_i && !wipe) |=> (flags_o == $past(flags_o)));

   assert_wipe_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wipe |=> (flags_o == '0 && on_q == '0 && det_q == '0));

   assert_sleep_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !$past(en_i)) |-> (gate_en_o == '0));

endmodule

// File: tb/test_outdrv_fault_guard.sv
`timescale 1ns/1ps
module test_outdrv_fault_guard;
   localparam int N  = 8;
   localparam int BL = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           en = 1'b0;
   logic           latch = 1'b0;
   logic [2*N-1:0] word = '0;
   logic [N-1:0]   trip = '0;
   logic [N-1:0]   hot = '0;
   logic           ov = 1'b0;
   logic           uv = 1'b0;
   logic           snap = 1'b0;
   logic [N-1:0]   flags;
   logic [N-1:0]   gate;

   always #10 clk = ~clk;

   outdrv_fault_guard #(.NCH(N), .BLANK_CYC(BL), .GATE_REG(1'b0)) i_outdrv_fault_guard (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cmd_latch_i(latch),
      .cmd_word_i(word), .cmp_trip_i(trip), .therm_i(hot), .ov_i(ov),
      .uv_i(uv), .snap_i(snap), .flags_o(flags), .gate_en_o(gate)
   );

   // Behavioural reference: integers and bit arrays updated on each edge.
   bit m_on [N];
   bit m_det[N];
   bit m_flg[N];
   int m_left;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N; k++) begin
            m_on[k] <= 0; m_det[k] <= 0; m_flg[k] <= 0;
         end
         m_left <= 0;
      end else if (uv || !en) begin
         for (int k = 0; k < N; k++) begin
            m_on[k] <= 0; m_det[k] <= 0; m_flg[k] <= 0;
         end
         m_left <= 0;
      end else begin
         for (int k = 0; k < N; k++) begin
            bit seen;
            seen = 0;
            if (!latch && m_left == 0) begin
               if (m_on[k]) seen = trip[k] || hot[k];
               else if (m_det[k] && trip[k]) seen = 1;
            end
            if (snap) m_flg[k] <= seen;
            else if (seen) m_flg[k] <= 1;
            if (latch) begin
               m_on[k]  <= word[k];
               m_det[k] <= word[N+k];
            end
         end
         if (latch) m_left <= BL;
         else if (m_left > 0) m_left <= m_left - 1;
      end
   end

   int    n_cmp = 0;
   int    n_bad = 0;
   string req = "R1";
   bit    finished = 0;

   task automatic tick();
      logic [N-1:0] ef, eg;
      @(negedge clk);
      for (int k = 0; k < N; k++) begin
         ef[k] = m_flg[k];
         eg[k] = m_on[k] && !hot[k] && !ov && !uv && en && rst_n;
      end
      n_cmp++;
      if (flags !== ef) begin
         n_bad++;
         $display("FAIL %s flags actual=%b expected=%b t=%0t", req, flags, ef, $time);
      end
      n_cmp++;
      if (gate !== eg) begin
         n_bad++;
         $display("FAIL %s gate actual=%b expected=%b t=%0t", req, gate, eg, $time);
      end
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) tick();
   endtask

   task automatic issue(input logic [N-1:0] det, input logic [N-1:0] on);
      word = {det, on}; latch = 1; tick(); latch = 0;
   endtask

   task automatic take_snap();
      snap = 1; tick(); snap = 0;
   endtask

   initial begin
      req = "R1"; ticks(3);
      rst_n = 1; en = 1; ticks(4);

      req = "R2"; issue(8'h0F, 8'hA5); ticks(BL + 3);
      issue(8'h00, 8'h3C); ticks(BL + 2);

      req = "R4"; issue(8'h0F, 8'h00); trip = 8'hFF; ticks(BL + 4);
      trip = 8'h00; ticks(2); take_snap(); ticks(2);

      req = "R5"; issue(8'h00, 8'hFF); trip = 8'h11; hot = 8'h20; ticks(BL + 4);
      trip = 0; hot = 0; take_snap(); ticks(2);

      req = "R3"; trip = 8'h01; issue(8'h00, 8'h01); ticks(3);
      issue(8'h00, 8'h01); ticks(BL - 1); trip = 8'h02; ticks(4); trip = 0;
      take_snap(); ticks(2);

      req = "R6"; trip = 8'h01; ticks(2); take_snap(); ticks(2);
      trip = 0; ticks(3); take_snap(); ticks(2);
      hot = 8'h01; word = 16'h0001; latch = 1; snap = 1; tick();
      latch = 0; snap = 0; ticks(BL + 2); hot = 0; take_snap(); ticks(2);

      req = "R7"; issue(8'h00, 8'hFF); ticks(BL + 1);
      hot = 8'h40; ticks(3); hot = 8'h00; ticks(2); hot = 8'h40; ticks(2);
      hot = 0; ticks(2); take_snap();

      req = "R8"; ov = 1; ticks(4); ov = 0; ticks(3);

      req = "R9"; uv = 1; ticks(3); uv = 0; ticks(4);
      issue(8'h00, 8'h81); ticks(3);

      req = "R10"; en = 0; ticks(3); en = 1; ticks(3);
      issue(8'hF0, 8'h0F); ticks(BL + 2);

      req = "R3";
      for (int r = 0; r < 600; r++) begin
         latch = ($urandom % 9) == 0;
         word  = 16'($urandom);
         trip  = 8'($urandom) & 8'($urandom);
         hot   = 8'($urandom) & 8'($urandom) & 8'($urandom);
         snap  = ($urandom % 5) == 0;
         ov    = ($urandom % 23) == 0;
         uv    = ($urandom % 41) == 0;
         en    = ($urandom % 53) != 0;
         tick();
      end
      latch = 0; snap = 0; ov = 0; uv = 0; en = 1; trip = 0; hot = 0;
      ticks(2);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule